// File: doc/BRIEF.md
# Regulator Control Register Interface over I2C

This block is a clocked I2C target that holds the small control and status register set of a programmable step-down regulator. It samples the serial clock and data lines with the system clock, passes them through synchronisers and a short agreement filter, and recognises START, repeated START and STOP. The target answers a single fixed 7-bit address. A parameter picks one of two addresses.

A write carries a register pointer and one data byte. A read first sets the pointer with a write phase. After a repeated START the target returns the byte at that pointer. The two rail registers and the CONTROL register drive field outputs towards the voltage ramp and sequencing logic. The status register reports live flags from that logic, plus an internal flag that records a software register reset. A high-speed master code after START is not acknowledged. It only raises a high-speed indication that stays up until the next STOP.

The SDA pad is driven as open drain through an active-high pull-down enable. The system clock must run at least 8 times faster than SCL.

Top module: `regctl_i2c_target`

## Requirements
- R1: Only the 7-bit address 1100000 is acknowledged (1100001 when ALT_ADDR_SEL=1). Any other address byte gets no ACK, and the transaction that follows has no effect on any register.
- R2: A write (START, address with R/W=0, pointer, data, STOP, each byte ACKed) to pointer 0x00 or 0x01 stores the byte. Bit 7 appears on `railN_en` and bits 6:0 on `railN_code`. No output changes without a write.
- R3: A read (pointer write, repeated START, address with R/W=1, one byte, NACK, STOP) returns the byte at the pointer, MSB first. `sda_oe` pulls SDA low only for ACK bits and for 0 data bits, and only starts to pull while SCL is low.
- R4: After reset, registers 0x00 and 0x01 read {1, RAIL_DEFAULT_CODE}. CONTROL (0x02) reads 0x82, 0x03 reads 0x81 and 0x04 reads 0x08. The reset-status bit (bit 2 of 0x05) is 0.
- R5: CONTROL bit 7 drives `discharge_en`, bits 6:4 drive `slew_code` and bits 1:0 drive `mode_bits`. Bits 3 and 2 always read 0.
- R6: Writing CONTROL with bit 2 set restores registers 0x00 to 0x02 to their reset values, ignores the other data bits, and sets the reset-status bit.
- R7: Register 0x05 returns `status_live` with bit 2 replaced by the reset-status bit. A read of 0x05 returns the bit as it stood, then clears it.
- R8: Writes to pointers 0x03 to 0xFF are acknowledged and change nothing. Reads of pointers above 0x05 return 0x00.
- R9: A byte 00001xxx received as the first byte after START, while not in high-speed mode, is not acknowledged and sets `hs_mode`. `hs_mode` holds across repeated STARTs, and transactions after a repeated START still work. STOP clears it.
- R10: A STOP at any point ends the transaction. `sda_oe` is released in the next cycle, and a write cut off before its data byte completes changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| hs_mode | output | 1 | High-speed master code seen since last STOP |
| rail0_en | output | 1 | Software enable, register 0x00 bit 7 |
| rail0_code | output | 7 | Output code, register 0x00 bits 6:0 |
| rail1_en | output | 1 | Software enable, register 0x01 bit 7 |
| rail1_code | output | 7 | Output code, register 0x01 bits 6:0 |
| discharge_en | output | 1 | Output discharge enable, CONTROL bit 7 |
| slew_code | output | 3 | Rising slew code, CONTROL bits 6:4 |
| mode_bits | output | 2 | Mode bits, CONTROL bits 1:0 |
| status_live | input | 8 | Live status flags for register 0x05 (bit 2 unused) |

## Verification
Two functions can fall in the same cycle. When a read of register 0x05 loads the transmit byte, the same cycle clears the reset-status flag. The bench provokes this by issuing a CONTROL soft reset with every live status bit held high, then reading 0x05 twice. It judges the result by the bytes seen on the wire: the first read must return 0xFF, with the flag still visible, and the second must return 0xFB. A checker property also requires the flag to be low in the cycle after the load.

// File: rtl/regctl_pkg.sv
package regctl_pkg;

    localparam logic [7:0] PTR_RAIL0 = 8'h00;
    localparam logic [7:0] PTR_RAIL1 = 8'h01;
    localparam logic [7:0] PTR_CTRL  = 8'h02;
    localparam logic [7:0] PTR_IDA   = 8'h03;
    localparam logic [7:0] PTR_IDB   = 8'h04;
    localparam logic [7:0] PTR_STAT  = 8'h05;

    localparam logic [7:0] IDA_VALUE = 8'h81;
    localparam logic [7:0] IDB_VALUE = 8'h08;
    localparam int         CTRL_RST_BIT  = 2;
    localparam int         STAT_FLAG_BIT = 2;
    localparam int         BITS_PER_BYTE = 8;

    typedef enum logic [2:0] {
        LK_IDLE, LK_RX, LK_ACK, LK_TX, LK_TXACK
    } link_state_t;

    typedef enum logic [1:0] {
        BK_ADDR, BK_PTR, BK_DATA
    } byte_kind_t;

    typedef struct packed {
        logic       discharge;
        logic [2:0] slew;
        logic [1:0] mode;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic       we;
        logic [7:0] ptr;
        logic [7:0] data;
    } wr_req_t;

    localparam ctrl_t CTRL_RESET = '{discharge: 1'b1, slew: 3'd0, mode: 2'b10};

    function automatic logic is_hs_code(input logic [7:0] b);
        return b[7:3] == 5'b00001;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        return {c.discharge, c.slew, 2'b00, c.mode};
    endfunction

    function automatic ctrl_t byte_to_ctrl(input logic [7:0] b);
        return '{discharge: b[7], slew: b[6:4], mode: b[1:0]};
    endfunction

endpackage

// File: rtl/regctl_bus_front.sv
module regctl_bus_front
    import regctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILTER_TAPS = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev,
    output logic    scl_level
);
    localparam int LANES = 2;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] lvl;
    logic [LANES-1:0] lvl_q;

    assign raw = {sda_in, scl_in};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SYNC_STAGES-1:0] sync_q;
        logic [FILTER_TAPS-1:0] hist;
        logic                   flt;
        logic                   flt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '1;
                hist   <= '1;
                flt    <= 1'b1;
                flt_q  <= 1'b1;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], raw[l]};
                hist   <= {hist[FILTER_TAPS-2:0], sync_q[SYNC_STAGES-1]};
                if (&hist)
                    flt <= 1'b1;
                else if (~|hist)
                    flt <= 1'b0;
                flt_q <= flt;
            end
        end

        assign lvl[l]   = flt;
        assign lvl_q[l] = flt_q;
    end

    // lane 0 carries SCL, lane 1 carries SDA
    assign ev.start  = lvl[0] & lvl_q[0] & lvl_q[1] & ~lvl[1];
    assign ev.stop   = lvl[0] & lvl_q[0] & ~lvl_q[1] & lvl[1];
    assign ev.rise   = lvl[0] & ~lvl_q[0];
    assign ev.fall   = ~lvl[0] & lvl_q[0];
    assign ev.sda    = lvl[1];
    assign scl_level = lvl[0];

endmodule

// File: rtl/regctl_link.sv
module regctl_link
    import regctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1100000
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [7:0] rd_data,
    output wr_req_t    wr,
    output logic [7:0] ptr,
    output logic       rd_load,
    output logic       sda_oe,
    output logic       hs_mode
);
    localparam int CNT_W = $clog2(BITS_PER_BYTE + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS_PER_BYTE);

    link_state_t      state;
    byte_kind_t       kind;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       sh;
    logic [7:0]       tx;
    logic             rnw;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LK_IDLE;
            kind    <= BK_ADDR;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            rnw     <= 1'b0;
            ptr     <= '0;
            wr      <= '0;
            rd_load <= 1'b0;
            sda_oe  <= 1'b0;
            hs_mode <= 1'b0;
        end else begin
            wr.we   <= 1'b0;
            rd_load <= 1'b0;
            if (ev.stop) begin
                state   <= LK_IDLE;
                sda_oe  <= 1'b0;
                hs_mode <= 1'b0;
            end else if (ev.start) begin
                state  <= LK_RX;
                kind   <= BK_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    LK_RX: begin
                        if (ev.rise) begin
                            sh  <= {sh[6:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.fall && cnt == FULL) begin
                            cnt <= '0;
                            unique case (kind)
                                BK_ADDR: begin
                                    if (!hs_mode && is_hs_code(sh)) begin
                                        hs_mode <= 1'b1;
                                        state   <= LK_IDLE;
                                    end else if (sh[7:1] == DEV_ADDR) begin
                                        rnw    <= sh[0];
                                        state  <= LK_ACK;
                                        sda_oe <= 1'b1;
                                    end else begin
                                        state <= LK_IDLE;
                                    end
                                end
                                BK_PTR: begin
                                    ptr    <= sh;
                                    state  <= LK_ACK;
                                    sda_oe <= 1'b1;
                                end
                                default: begin
                                    wr     <= '{we: 1'b1, ptr: ptr, data: sh};
                                    state  <= LK_ACK;
                                    sda_oe <= 1'b1;
                                end
                            endcase
                        end
                    end
                    LK_ACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            if (kind == BK_ADDR && rnw) begin
                                state   <= LK_TX;
                                tx      <= rd_data;
                                rd_load <= 1'b1;
                                sda_oe  <= ~rd_data[7];
                            end else if (kind == BK_ADDR) begin
                                state <= LK_RX;
                                kind  <= BK_PTR;
                            end else if (kind == BK_PTR) begin
                                state <= LK_RX;
                                kind  <= BK_DATA;
                            end else begin
                                state <= LK_IDLE;
                            end
                        end
                    end
                    LK_TX: begin
                        if (ev.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.fall) begin
                            if (cnt == FULL) begin
                                state  <= LK_TXACK;
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                            end else begin
                                tx     <= {tx[6:0], 1'b0};
                                sda_oe <= ~tx[6];
                            end
                        end
                    end
                    LK_TXACK: begin
                        if (ev.rise)
                            state <= LK_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/regctl_regs.sv
module regctl_regs
    import regctl_pkg::*;
#(
    parameter logic [6:0] RAIL_DEFAULT_CODE = 7'd84
) (
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr,
    input  logic [7:0] rd_ptr,
    input  logic       rd_load,
    input  logic [7:0] status_live,
    output logic [7:0] rd_data,
    output logic [7:0] rail0,
    output logic [7:0] rail1,
    output ctrl_t      ctrl,
    output logic       rst_flag
);
    localparam int RAILS = 2;
    localparam logic [7:0] RAIL_RESET = {1'b1, RAIL_DEFAULT_CODE};

    logic                 soft_rst;
    logic [RAILS*8-1:0]   rail_bus;
    logic [7:0]           stat_byte;

    assign soft_rst = wr.we && wr.ptr == PTR_CTRL && wr.data[CTRL_RST_BIT];

    for (genvar r = 0; r < RAILS; r++) begin : g_rail
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst || soft_rst)
                q <= RAIL_RESET;
            else if (wr.we && wr.ptr == 8'(r))
                q <= wr.data;
        end
        assign rail_bus[r*8 +: 8] = q;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            ctrl <= CTRL_RESET;
        else if (wr.we && wr.ptr == PTR_CTRL)
            ctrl <= byte_to_ctrl(wr.data);
    end

    always_ff @(posedge clk) begin
        if (rst)
            rst_flag <= 1'b0;
        else if (soft_rst)
            rst_flag <= 1'b1;
        else if (rd_load && rd_ptr == PTR_STAT)
            rst_flag <= 1'b0;
    end

    always_comb begin
        stat_byte = status_live;
        stat_byte[STAT_FLAG_BIT] = rst_flag;
    end

    always_comb begin
        unique case (rd_ptr)
            PTR_RAIL0: rd_data = rail_bus[7:0];
            PTR_RAIL1: rd_data = rail_bus[15:8];
            PTR_CTRL:  rd_data = ctrl_to_byte(ctrl);
            PTR_IDA:   rd_data = IDA_VALUE;
            PTR_IDB:   rd_data = IDB_VALUE;
            PTR_STAT:  rd_data = stat_byte;
            default:   rd_data = 8'h00;
        endcase
    end

    assign rail0 = rail_bus[7:0];
    assign rail1 = rail_bus[15:8];

endmodule

// File: rtl/regctl_i2c_target.sv
module regctl_i2c_target
    import regctl_pkg::*;
#(
    parameter bit         ALT_ADDR_SEL      = 1'b0,
    parameter logic [6:0] RAIL_DEFAULT_CODE = 7'd84,
    parameter int         SYNC_STAGES       = 2,
    parameter int         FILTER_TAPS       = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic       hs_mode,
    output logic       rail0_en,
    output logic [6:0] rail0_code,
    output logic       rail1_en,
    output logic [6:0] rail1_code,
    output logic       discharge_en,
    output logic [2:0] slew_code,
    output logic [1:0] mode_bits,
    input  logic [7:0] status_live
);
    localparam logic [6:0] DEV_ADDR = {6'b110000, ALT_ADDR_SEL};

    bus_ev_t    ev;
    logic       scl_level;
    wr_req_t    wr;
    logic [7:0] link_ptr;
    logic       rd_load;
    logic [7:0] rd_data;
    logic [7:0] rail0;
    logic [7:0] rail1;
    ctrl_t      ctrl;
    logic       rst_flag;

    regctl_bus_front #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILTER_TAPS(FILTER_TAPS)
    ) u_front (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .ev       (ev),
        .scl_level(scl_level)
    );

    regctl_link #(
        .DEV_ADDR(DEV_ADDR)
    ) u_link (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .rd_data(rd_data),
        .wr     (wr),
        .ptr    (link_ptr),
        .rd_load(rd_load),
        .sda_oe (sda_oe),
        .hs_mode(hs_mode)
    );

    regctl_regs #(
        .RAIL_DEFAULT_CODE(RAIL_DEFAULT_CODE)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .rd_ptr     (link_ptr),
        .rd_load    (rd_load),
        .status_live(status_live),
        .rd_data    (rd_data),
        .rail0      (rail0),
        .rail1      (rail1),
        .ctrl       (ctrl),
        .rst_flag   (rst_flag)
    );

    assign rail0_en     = rail0[7];
    assign rail0_code   = rail0[6:0];
    assign rail1_en     = rail1[7];
    assign rail1_code   = rail1[6:0];
    assign discharge_en = ctrl.discharge;
    assign slew_code    = ctrl.slew;
    assign mode_bits    = ctrl.mode;

endmodule

// File: rtl/regctl_checker.sv
module regctl_checker #(
    parameter logic [6:0] RAIL_DEFAULT_CODE = 7'd84
) (
    input logic       clk,
    input logic       rst,
    input logic       stop_ev,
    input logic       scl_level,
    input logic       sda_oe,
    input logic       hs_mode,
    input logic       wr_we,
    input logic [7:0] wr_ptr,
    input logic [7:0] wr_data,
    input logic       rd_load,
    input logic [7:0] rd_ptr,
    input logic       rst_flag,
    input logic       rail0_en,
    input logic [6:0] rail0_code,
    input logic       rail1_en,
    input logic [6:0] rail1_code,
    input logic       discharge_en,
    input logic [2:0] slew_code,
    input logic [1:0] mode_bits
);
    logic [21:0] outs;
    assign outs = {rail0_en, rail0_code, rail1_en, rail1_code,
                   discharge_en, slew_code, mode_bits};

    AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe);                                        // R10

    AST_STOP_ENDS_HS: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !hs_mode);                                       // R9

    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_level);                               // R3

    AST_SOFT_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        (wr_we && wr_ptr == 8'h02 && wr_data[2]) |=>
        (rail0_en && rail0_code == RAIL_DEFAULT_CODE && rail1_en &&
         rail1_code == RAIL_DEFAULT_CODE && discharge_en &&
         slew_code == 3'd0 && mode_bits == 2'b10 && rst_flag));      // R6

    AST_FLAG_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_load && rd_ptr == 8'h05 && !wr_we) |=> !rst_flag);       // R7

    AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (wr_we && wr_ptr > 8'h02) |=> $stable(outs));                // R8

    AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_we |=> $stable(outs));                                   // R2

endmodule

bind regctl_i2c_target regctl_checker #(
    .RAIL_DEFAULT_CODE(RAIL_DEFAULT_CODE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stop_ev     (ev.stop),
    .scl_level   (scl_level),
    .sda_oe      (sda_oe),
    .hs_mode     (hs_mode),
    .wr_we       (wr.we),
    .wr_ptr      (wr.ptr),
    .wr_data     (wr.data),
    .rd_load     (rd_load),
    .rd_ptr      (link_ptr),
    .rst_flag    (rst_flag),
    .rail0_en    (rail0_en),
    .rail0_code  (rail0_code),
    .rail1_en    (rail1_en),
    .rail1_code  (rail1_code),
    .discharge_en(discharge_en),
    .slew_code   (slew_code),
    .mode_bits   (mode_bits)
);

// File: tb/regctl_i2c_target_test.sv
module regctl_i2c_target_test;

    localparam int         H        = 16;
    localparam logic [6:0] DEVA     = 7'b1100000;
    localparam logic [6:0] DEF_CODE = 7'd84;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic [7:0] status_live = 8'h00;

    logic       sda_oe, hs_mode, rail0_en, rail1_en, discharge_en;
    logic [6:0] rail0_code, rail1_code;
    logic [2:0] slew_code;
    logic [1:0] mode_bits;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_r0, m_r1, m_ctrl;
    logic       m_flag;

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    regctl_i2c_target uut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_oe(sda_oe), .hs_mode(hs_mode),
        .rail0_en(rail0_en), .rail0_code(rail0_code),
        .rail1_en(rail1_en), .rail1_code(rail1_code),
        .discharge_en(discharge_en), .slew_code(slew_code),
        .mode_bits(mode_bits), .status_live(status_live)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        if (!m_scl) begin
            m_sda = 1'b1; tick(H);
            m_scl = 1'b1; tick(H);
        end
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(H);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H/2);
        ack = ~sda_bus; tick(H/2);
        m_scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            m_scl = 1'b1; tick(H/2);
            b[i] = sda_bus; tick(H/2);
            m_scl = 1'b0;
        end
        m_sda = nack; tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0;
    endtask

    task automatic model_write(input logic [7:0] p, input logic [7:0] d);
        if (p == 8'h00) m_r0 = d;
        else if (p == 8'h01) m_r1 = d;
        else if (p == 8'h02) begin
            if (d[2]) begin
                m_r0 = {1'b1, DEF_CODE}; m_r1 = {1'b1, DEF_CODE};
                m_ctrl = 8'h82; m_flag = 1'b1;
            end else m_ctrl = d & 8'hF3;
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] p);
        case (p)
            8'h00: return m_r0;
            8'h01: return m_r1;
            8'h02: return m_ctrl;
            8'h03: return 8'h81;
            8'h04: return 8'h08;
            8'h05: return (status_live & 8'hFB) | {5'b0, m_flag, 2'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic wr_reg(input string tag, input logic [7:0] p, input logic [7:0] d);
        logic a0, a1, a2;
        bus_start();
        send_byte({DEVA, 1'b0}, a0);
        send_byte(p, a1);
        send_byte(d, a2);
        bus_stop();
        check({tag, " write acks"}, {a0, a1, a2}, 3'b111);
        model_write(p, d);
    endtask

    task automatic rd_reg(input string tag, input logic [7:0] p);
        logic a0, a1, a2;
        logic [7:0] d, e;
        e = model_read(p);
        bus_start();
        send_byte({DEVA, 1'b0}, a0);
        send_byte(p, a1);
        bus_start();
        send_byte({DEVA, 1'b1}, a2);
        recv_byte(d, 1'b1);
        bus_stop();
        check({tag, " read acks"}, {a0, a1, a2}, 3'b111);
        check({tag, " read data"}, d, e);
        if (p == 8'h05) m_flag = 1'b0;
    endtask

    task automatic check_outs(input string tag);
        check({tag, " outputs"},
              {rail0_en, rail0_code, rail1_en, rail1_code, discharge_en, slew_code, mode_bits},
              {m_r0, m_r1, m_ctrl[7:4], m_ctrl[1:0]});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic ack;
        m_r0 = {1'b1, DEF_CODE}; m_r1 = {1'b1, DEF_CODE};
        m_ctrl = 8'h82; m_flag = 1'b0;
        tick(5);
        rst = 1'b0;
        tick(10);

        // R4: reset state at the ports and in every register
        check("R4 reset outputs",
              {rail0_en, rail0_code, rail1_en, rail1_code, discharge_en, slew_code, mode_bits, sda_oe, hs_mode},
              {1'b1, DEF_CODE, 1'b1, DEF_CODE, 1'b1, 3'd0, 2'b10, 1'b0, 1'b0});
        for (int p = 0; p < 6; p++) rd_reg("R4 default", 8'(p));
        // R8: unmapped reads
        rd_reg("R8 unmapped 0x06", 8'h06);
        rd_reg("R8 unmapped 0xFF", 8'hFF);

        // R2 R3: sweep of rail codes and enables
        for (int k = 0; k < 6; k++) begin
            wr_reg("R2 rail0", 8'h00, 8'((k * 43 + 5) & 8'hFF));
            check_outs("R2 rail0");
            rd_reg("R3 rail0", 8'h00);
            wr_reg("R2 rail1", 8'h01, 8'((k * 91 + 130) & 8'hFF));
            check_outs("R2 rail1");
            rd_reg("R3 rail1", 8'h01);
        end

        // R5: every slew code, reserved bit 3 written as 1
        for (int s = 0; s < 8; s++) begin
            wr_reg("R5 ctrl", 8'h02, {s[0], 3'(s), 1'b1, 1'b0, 2'(s + 1)});
            check_outs("R5 ctrl");
            rd_reg("R5 ctrl", 8'h02);
        end

        // R8: read-only and unmapped writes are acked and change nothing
        wr_reg("R8 ro 0x03", 8'h03, 8'h00);
        wr_reg("R8 ro 0x04", 8'h04, 8'hFF);
        wr_reg("R8 ro 0x05", 8'h05, 8'hFF);
        wr_reg("R8 unmapped 0x09", 8'h09, 8'h55);
        check_outs("R8 after ro writes");
        rd_reg("R8 id a", 8'h03);
        rd_reg("R8 id b", 8'h04);
        rd_reg("R8 status", 8'h05);
        rd_reg("R8 unmapped 0x09", 8'h09);

        // R1: full address sweep, then a foreign write must not land
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            bus_stop();
            check($sformatf("R1 addr %0h", a), ack, (7'(a) == DEVA));
        end
        bus_start();
        send_byte({7'b1100001, 1'b0}, ack);
        send_byte(8'h00, ack);
        send_byte(8'h3C, ack);
        bus_stop();
        check_outs("R1 foreign write ignored");

        // R9: master code, then transfers after repeated START
        bus_start();
        send_byte(8'h0B, ack);
        check("R9 master code nack", ack, 1'b0);
        check("R9 hs set", hs_mode, 1'b1);
        bus_start();
        send_byte({DEVA, 1'b0}, ack);
        check("R9 addr ack in hs", ack, 1'b1);
        send_byte(8'h00, ack);
        send_byte(8'h11, ack);
        model_write(8'h00, 8'h11);
        bus_start();
        check("R9 hs held over repeated start", hs_mode, 1'b1);
        bus_stop();
        check("R9 hs cleared by stop", hs_mode, 1'b0);
        check_outs("R9 write in hs");

        // R10: STOP before the data byte
        bus_start();
        send_byte({DEVA, 1'b0}, ack);
        send_byte(8'h01, ack);
        bus_stop();
        tick(4);
        check("R10 sda released", sda_oe, 1'b0);
        check_outs("R10 aborted write");

        // R6 R7: soft reset, status read with live bits high
        wr_reg("R6 ctrl", 8'h02, 8'h7B);
        wr_reg("R6 soft reset", 8'h02, 8'h04);
        check_outs("R6 defaults restored");
        status_live = 8'hFF;
        tick(2);
        rd_reg("R7 status flag set", 8'h05);
        rd_reg("R7 status flag cleared", 8'h05);
        rd_reg("R6 rail0 default", 8'h00);
        rd_reg("R6 ctrl default", 8'h02);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule